// File: doc/BRIEF.md
# Command-Byte I2C Target Interface

This block is the serial front end of a dual-wiper attenuator controller. It listens on an I2C bus as a target whose 7-bit address is the fixed prefix 0101 followed by three strap pins. Every data byte of a write is a self-contained command: its two top bits choose the destination and its low bits carry the value. One write may hold any number of commands, so both wipers and the configuration can be changed in a single transaction.

The block does not hold the register values itself. Each accepted command is issued as a one-cycle update strobe with the value beside it, toward the logic that schedules wiper moves and commits settings. Reads are served from the register values that this logic feeds back. They return a fixed three-byte cycle that repeats for as long as the master keeps acknowledging.

An active-low enable input shuts the interface off the bus. A busy input from the commit side makes the block refuse its address. SCL, SDA and the enable are first passed through a synchroniser, and the block then runs on a fast system clock that detects START, STOP and the clock edges. SDA is driven only through an open-drain output enable. The block never stretches the clock.

Top module: `cmdbyte_i2c_target`

## Requirements
- R1: The block acknowledges an address byte, by pulling SDA low during the 9th clock, only when bits 7..1 equal 0101 followed by addr_pins_i[2:0] (bit 3 of the address is pin 2). Bit 0 selects a read when it is 1 and a write when it is 0.
- R2: While bus_en_n_i is high, the block never drives SDA and issues no update strobe, whatever happens on SCL and SDA.
- R3: A written data byte with bits 7:6 = 00 produces a one-cycle upd_w0_o pulse, with upd_val_o equal to bits 5:0 of the byte.
- R4: A written data byte with bits 7:6 = 01 produces a one-cycle upd_w1_o pulse, with upd_val_o equal to bits 5:0 of the byte.
- R5: A written data byte with bits 7:6 = 10 produces a one-cycle upd_cfg_o pulse, with upd_val_o[2:0] equal to bits 2:0 of the byte. Bits 5:3 of the byte are ignored.
- R6: A written data byte with bits 7:6 = 11 is acknowledged but produces no strobe.
- R7: Several command bytes in one write, in any order, each produce exactly one strobe, in the order they arrive, after the acknowledge of that byte. At most one strobe is active in any cycle.
- R8: A read returns {00,wiper0}, then {01,wiper1}, then {10,000,cfg}, and then wraps to wiper 0 as long as the master acknowledges each byte. Bits go out MSB first and change only after a falling SCL edge.
- R9: After an address that does not match, the block drives nothing and issues no strobe until the next START.
- R10: While busy_i is high when the address byte completes, the address is not acknowledged and the rest of the transaction is ignored.
- R11: Every START, including a repeated START, restarts the read cycle at wiper 0.
- R12: A master NACK on a read byte makes the block release SDA and stay silent until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| bus_en_n_i | input | 1 | Active-low enable of the bus interface |
| addr_pins_i | input | 3 | Strap pins forming the low address bits |
| busy_i | input | 1 | Commit in progress; suppresses address acknowledge |
| rd_w0_i | input | 6 | Current wiper 0 value for read-back |
| rd_w1_i | input | 6 | Current wiper 1 value for read-back |
| rd_cfg_i | input | 3 | Current configuration value for read-back |
| upd_w0_o | output | 1 | One-cycle strobe: load wiper 0 |
| upd_w1_o | output | 1 | One-cycle strobe: load wiper 1 |
| upd_cfg_o | output | 1 | One-cycle strobe: load configuration |
| upd_val_o | output | 6 | Value carried with the strobe (low 3 bits for configuration) |

## Verification
Writes send all four select codes, both wipers twice with reordering, and the all-zero and all-one wiper values. These separate a decoder that drops or repeats commands from one that masks fields wrongly. A configuration byte with its unused bits set shows whether those bits reach the value. Reads longer than three bytes expose wrap and ordering faults. A NACK on the first byte followed by a repeated START separates a pointer that restarts from one that carries on. Wrong addresses, a changed strap value, busy and a disabled enable each check acknowledge gating on its own, because a command follows that would otherwise produce a strobe.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  localparam int BYTE_W     = 8;
  localparam int WIPER_W    = 6;
  localparam int CFG_W      = 3;
  localparam int ADDR_PIN_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_IGN
  } cbi_state_t;

  typedef enum logic [1:0] {
    SEL_W0 = 2'b00, SEL_W1 = 2'b01, SEL_CFG = 2'b10, SEL_RSV = 2'b11
  } cbi_sel_t;

  // Address bits 7..1 against fixed prefix plus strap pins
  function automatic logic addr_match(input logic [BYTE_W-1:0] b,
                                      input logic [3:0] hi,
                                      input logic [ADDR_PIN_W-1:0] pins);
    return b[BYTE_W-1:1] == {hi, pins};
  endfunction

  // Read cycle slot after the given one: 0 -> 1 -> 2 -> 0
  function automatic logic [1:0] next_slot(input logic [1:0] s);
    return (s == 2'd2) ? 2'd0 : s + 2'd1;
  endfunction

  // Byte returned for a read slot, select code in the top two bits
  function automatic logic [BYTE_W-1:0] readback_byte(input logic [1:0] s,
                                                      input logic [WIPER_W-1:0] w0,
                                                      input logic [WIPER_W-1:0] w1,
                                                      input logic [CFG_W-1:0] cfg);
    logic [BYTE_W-1:0] b;
    case (s)
      2'd0:    b = {SEL_W0, w0};
      2'd1:    b = {SEL_W1, w1};
      default: b = {SEL_CFG, {(BYTE_W-2-CFG_W){1'b0}}, cfg};
    endcase
    return b;
  endfunction
endpackage

// File: rtl/cbi_line_sync.sv
module cbi_line_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // One shift chain per lane; lanes reset to the idle-high level
  for (genvar lane = 0; lane < WIDTH; lane++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i[lane]};
    end
    assign q_o[lane] = chain[STAGES-1];
  end
endmodule

// File: rtl/cbi_bus_events.sv
module cbi_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/cbi_cmd_decode.sv
module cbi_cmd_decode
  import cbi_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic              fire_i,
  output logic              hit_w0_o,
  output logic              hit_w1_o,
  output logic              hit_cfg_o
);
  cbi_sel_t sel;
  assign sel       = cbi_sel_t'(cmd_i[BYTE_W-1 -: 2]);
  assign hit_w0_o  = fire_i && (sel == SEL_W0);
  assign hit_w1_o  = fire_i && (sel == SEL_W1);
  assign hit_cfg_o = fire_i && (sel == SEL_CFG);
endmodule

// File: rtl/cmdbyte_i2c_target.sv
module cmdbyte_i2c_target
  import cbi_pkg::*;
#(
  parameter logic [3:0] ADDR_HI     = 4'b0101,
  parameter int         SYNC_STAGES = 2
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic                  bus_en_n_i,
  input  logic [ADDR_PIN_W-1:0] addr_pins_i,
  input  logic                  busy_i,
  input  logic [WIPER_W-1:0]    rd_w0_i,
  input  logic [WIPER_W-1:0]    rd_w1_i,
  input  logic [CFG_W-1:0]      rd_cfg_i,
  output logic                  upd_w0_o,
  output logic                  upd_w1_o,
  output logic                  upd_cfg_o,
  output logic [WIPER_W-1:0]    upd_val_o
);
  localparam int LINE_N = 3;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  // Synchronised lines
  logic [LINE_N-1:0] raw_lines, sync_lines;
  logic scl_s, sda_s, gate_off;
  assign raw_lines = {bus_en_n_i, sda_i, scl_i};

  cbi_line_sync #(.WIDTH(LINE_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_lines), .q_o(sync_lines)
  );
  assign scl_s    = sync_lines[0];
  assign sda_s    = sync_lines[1];
  assign gate_off = sync_lines[2];

  // Bus events
  logic scl_rise, scl_fall, start_ev, stop_ev;
  cbi_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  // State
  cbi_state_t        st;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg, txreg;
  logic [1:0]        slot;
  logic              rd_mode, mack;

  // Named internal events
  logic              addr_hit_w, addr_take_w, byte_full_w, cmd_fire_w;
  logic [1:0]        slot_next_w;
  logic [BYTE_W-1:0] rb_now_w, rb_next_w;
  logic              dec_w0, dec_w1, dec_cfg, upd_any_w;

  assign addr_hit_w  = addr_match(shreg, ADDR_HI, addr_pins_i);
  assign addr_take_w = addr_hit_w & ~busy_i;
  assign byte_full_w = (bit_cnt == FULL);
  assign cmd_fire_w  = (st == ST_WACK) & scl_fall & ~gate_off;
  assign slot_next_w = next_slot(slot);
  assign rb_now_w    = readback_byte(slot, rd_w0_i, rd_w1_i, rd_cfg_i);
  assign rb_next_w   = readback_byte(slot_next_w, rd_w0_i, rd_w1_i, rd_cfg_i);
  assign upd_any_w   = upd_w0_o | upd_w1_o | upd_cfg_o;

  cbi_cmd_decode u_dec (
    .cmd_i(shreg), .fire_i(cmd_fire_w),
    .hit_w0_o(dec_w0), .hit_w1_o(dec_w1), .hit_cfg_o(dec_cfg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      txreg     <= '0;
      slot      <= 2'd0;
      rd_mode   <= 1'b0;
      mack      <= 1'b0;
      sda_oe_o  <= 1'b0;
      upd_w0_o  <= 1'b0;
      upd_w1_o  <= 1'b0;
      upd_cfg_o <= 1'b0;
      upd_val_o <= '0;
    end else begin
      upd_w0_o  <= dec_w0;
      upd_w1_o  <= dec_w1;
      upd_cfg_o <= dec_cfg;
      if (cmd_fire_w) upd_val_o <= shreg[WIPER_W-1:0];

      if (gate_off) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
        rd_mode  <= 1'b0;
      end else if (start_ev) begin
        st       <= ST_ADDR;
        bit_cnt  <= '0;
        slot     <= 2'd0;
        rd_mode  <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_ev) begin
        st       <= ST_IDLE;
        rd_mode  <= 1'b0;
        sda_oe_o <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && byte_full_w) begin
              bit_cnt <= '0;
              if (st == ST_WDATA) begin
                sda_oe_o <= 1'b1;
                st       <= ST_WACK;
              end else if (addr_take_w) begin
                sda_oe_o <= 1'b1;
                st       <= ST_AACK;
              end else begin
                sda_oe_o <= 1'b0;
                st       <= ST_IGN;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              if (shreg[0]) begin
                rd_mode  <= 1'b1;
                sda_oe_o <= ~rb_now_w[BYTE_W-1];
                txreg    <= {rb_now_w[BYTE_W-2:0], 1'b0};
                st       <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                st       <= ST_WDATA;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              st       <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (byte_full_w) begin
                bit_cnt  <= '0;
                sda_oe_o <= 1'b0;
                st       <= ST_RACK;
              end else begin
                sda_oe_o <= ~txreg[BYTE_W-1];
                txreg    <= {txreg[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                slot     <= slot_next_w;
                sda_oe_o <= ~rb_next_w[BYTE_W-1];
                txreg    <= {rb_next_w[BYTE_W-2:0], 1'b0};
                st       <= ST_RDATA;
              end else begin
                rd_mode <= 1'b0;
                st      <= ST_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Assertions next to the logic they guard
  AST_ACK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AACK && $past(st) == ST_ADDR) |-> ($past(shreg[BYTE_W-1:1]) == {ADDR_HI, $past(addr_pins_i)})); // R1
  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AACK && $past(st) == ST_ADDR) |-> !$past(busy_i)); // R10
  AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off |=> (!sda_oe_o && !upd_any_w)); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_w0_o, upd_w1_o, upd_cfg_o})); // R7
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_any_w |=> !upd_any_w); // R3
  AST_READ_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode |-> !upd_any_w); // R8
  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGN) |-> !sda_oe_o); // R9
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !gate_off) |=> (st == ST_ADDR && slot == 2'd0)); // R11
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGN && $past(st) == ST_RACK) |-> !sda_oe_o); // R12
endmodule

// File: tb/sim_cmdbyte_i2c_target.sv
module sim_cmdbyte_i2c_target;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1, bus_en_n = 1'b0, busy = 1'b0;
  logic [2:0] pins = 3'b101;
  logic sda_oe, sda_bus;
  logic upd_w0, upd_w1, upd_cfg;
  logic [5:0] upd_val;
  logic [5:0] rf_w0 = '0, rf_w1 = '0;
  logic [2:0] rf_cfg = '0;
  assign sda_bus = m_sda & ~sda_oe;

  cmdbyte_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .bus_en_n_i(bus_en_n), .addr_pins_i(pins), .busy_i(busy),
    .rd_w0_i(rf_w0), .rd_w1_i(rf_w1), .rd_cfg_i(rf_cfg),
    .upd_w0_o(upd_w0), .upd_w1_o(upd_w1), .upd_cfg_o(upd_cfg), .upd_val_o(upd_val)
  );

  int n_cmp = 0, n_bad = 0;
  int exp_q[$];
  logic [5:0] ex_w0 = '0, ex_w1 = '0;
  logic [2:0] ex_cfg = '0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison of strobes against the expected command queue
  int code;
  always @(negedge clk) begin
    if (rst_n && (upd_w0 || upd_w1 || upd_cfg)) begin
      code = upd_w0 ? int'(upd_val) : upd_w1 ? 64 + int'(upd_val) : 128 + int'(upd_val[2:0]);
      if (upd_w0) rf_w0 = upd_val;
      if (upd_w1) rf_w1 = upd_val;
      if (upd_cfg) rf_cfg = upd_val[2:0];
      if ((int'(upd_w0) + int'(upd_w1) + int'(upd_cfg)) != 1) chk("R7 strobe count", 2, 1);
      if (exp_q.size() == 0) chk("R7 unexpected strobe", code, -1);
      else chk("R3/R4/R5 strobe value", code, exp_q.pop_front());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    b = sda_bus; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ackbit);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ackbit);
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(~give_ack);
  endtask

  // Address byte: expected acknowledge bit given (0 = ACK)
  task automatic send_addr(input string tag, input logic [7:0] a, input logic exp_bit);
    logic ab;
    send_byte(a, ab);
    chk(tag, int'(ab), int'(exp_bit));
  endtask

  // Command byte in a write; live = transaction was acknowledged
  task automatic send_cmd(input logic [7:0] c, input logic live);
    logic ab;
    if (live) begin
      case (c[7:6])
        2'b00: begin exp_q.push_back(int'(c[5:0]));       ex_w0 = c[5:0]; end
        2'b01: begin exp_q.push_back(64 + int'(c[5:0]));  ex_w1 = c[5:0]; end
        2'b10: begin exp_q.push_back(128 + int'(c[2:0])); ex_cfg = c[2:0]; end
        default: ;
      endcase
    end
    send_byte(c, ab);
    chk(live ? "R6/R7 command ACK" : "R9/R10/R2 command ignored", int'(ab), live ? 0 : 1);
  endtask

  task automatic expect_read(input string tag, input int slot, input logic give_ack);
    logic [7:0] v, e;
    case (slot)
      0: e = {2'b00, ex_w0};
      1: e = {2'b01, ex_w1};
      default: e = {2'b10, 3'b000, ex_cfg};
    endcase
    recv_byte(v, give_ack);
    chk(tag, int'(v), int'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(4);
    chk("reset sda_oe", int'(sda_oe), 0);
    chk("reset strobes", int'(upd_w0 | upd_w1 | upd_cfg), 0);
    rst_n = 1'b1;
    tick(10);

    // R1 R3 R4 R5 R6 R7: multi-command write, reordered, reserved code
    bus_start();
    send_addr("R1 address ACK pins=101", 8'h5A, 1'b0);
    send_cmd(8'h15, 1'b1);
    send_cmd(8'h6A, 1'b1);
    send_cmd(8'hBD, 1'b1);
    send_cmd(8'hC5, 1'b1);
    send_cmd(8'h3F, 1'b1);
    bus_stop();
    tick(20);
    chk("R7 all commands strobed", exp_q.size(), 0);

    // R8 R12: read with wrap, NACK release
    bus_start();
    send_addr("R1 read address ACK", 8'h5B, 1'b0);
    expect_read("R8 read slot w0", 0, 1'b1);
    expect_read("R8 read slot w1", 1, 1'b1);
    expect_read("R8 read slot cfg", 2, 1'b1);
    expect_read("R8 read wrap to w0", 0, 1'b0);
    tick(Q);
    chk("R12 SDA released after NACK", int'(sda_oe), 0);
    bus_stop();

    // R9: mismatched addresses
    bus_start();
    send_addr("R9 wrong pins NACK", 8'h58, 1'b1);
    send_cmd(8'h01, 1'b0);
    bus_stop();
    bus_start();
    send_addr("R9 wrong prefix NACK", 8'h7A, 1'b1);
    send_cmd(8'h42, 1'b0);
    bus_stop();
    tick(20);
    chk("R9 no strobe after mismatch", exp_q.size(), 0);

    // R1 R3 R4: new strap value, boundary wiper values
    pins = 3'b010;
    tick(4);
    bus_start();
    send_addr("R1 old address now NACK", 8'h5A, 1'b1);
    bus_stop();
    bus_start();
    send_addr("R1 address ACK pins=010", 8'h54, 1'b0);
    send_cmd(8'h00, 1'b1);
    send_cmd(8'h7F, 1'b1);
    bus_stop();
    tick(20);
    chk("R3/R4 boundary strobes", exp_q.size(), 0);

    // R10: busy suppresses address ACK
    busy = 1'b1;
    bus_start();
    send_addr("R10 busy NACK", 8'h54, 1'b1);
    send_cmd(8'h11, 1'b0);
    bus_stop();
    busy = 1'b0;

    // R2: interface disabled
    bus_en_n = 1'b1;
    tick(10);
    bus_start();
    send_addr("R2 disabled NACK", 8'h54, 1'b1);
    send_cmd(8'h22, 1'b0);
    bus_stop();
    chk("R2 SDA not driven while disabled", int'(sda_oe), 0);
    bus_en_n = 1'b0;
    tick(10);

    // R11: repeated START restarts read at w0
    bus_start();
    send_addr("R11 write address", 8'h54, 1'b0);
    send_cmd(8'h2C, 1'b1);
    bus_start();
    send_addr("R11 read after Sr", 8'h55, 1'b0);
    expect_read("R11 first byte after Sr is w0", 0, 1'b0);
    bus_start();
    send_addr("R11 second Sr read", 8'h55, 1'b0);
    expect_read("R11 pointer restarted at w0", 0, 1'b1);
    expect_read("R8 then w1", 1, 1'b0);
    bus_stop();

    // R5: unused configuration bits ignored, read back
    bus_start();
    send_addr("R5 write address", 8'h54, 1'b0);
    send_cmd(8'hBA, 1'b1);
    bus_start();
    send_addr("R5 read address", 8'h55, 1'b0);
    expect_read("R5 w0", 0, 1'b1);
    expect_read("R5 w1", 1, 1'b1);
    expect_read("R5 cfg low bits only", 2, 1'b0);
    bus_stop();

    tick(50);
    chk("R7 queue drained at end", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule